// File: doc/BRIEF.md
# Three-Slot Layered Decoder Issue Scheduler

This block sequences the reads of a layered LDPC decoder whose parity-check matrix is split over three processing slots. The matrix is held as a per-slot program. Each program row gives every slot an APP memory word address and a cyclic shift amount. Submatrix column c belongs to slot c mod 3 at word address c div 3, so slot s holds the APP words of the columns 3i+s. A row also carries a marker that closes the current check node. The scheduler walks this program row by row. It presents the row index on `vec_idx` and receives that row's entries in the same cycle. For each row it issues, it drives each slot's read address and shift one cycle later, together with flags for the first and last row of a check node.

An entry whose slot field is -1 is padding. That slot makes no memory access for the row, and the other slots proceed normally. The updated APP words of a check node return to memory a fixed number of cycles after the check node's last row. Each slot therefore keeps a small table of the addresses that are still in flight. A row of a later check node that reads one of those addresses is held back until the write has landed. Shift values pass through unchanged.

After the last row, the program wraps to row 0 and the iteration count rises. Decoding ends when the count reaches the requested limit, or at the end of any iteration in which the parity-satisfied input is high.

Top module: `ldpc_slot_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `stall`, `row_issue`, `cn_start`, `cn_end`, `done` and all `slot_valid` bits are 0, and `iter_count` is 0.
- R2: A `start` seen while idle starts a run. Row 0 can issue at the clock edge that follows. Rows issue in program order, one per cycle, unless stalled. While `busy`, `vec_idx` holds the index of the next row to issue. `row_issue` is high for exactly one cycle per issued row and is low otherwise.
- R3: The entries of slot s sit in `vec_addr[s*(ADDR_W+1) +: ADDR_W+1]` and `vec_shift[s*SH_W +: SH_W]`. On an issued row, `slot_addr[s*ADDR_W +: ADDR_W]` and `slot_shift[s*SH_W +: SH_W]` repeat that slot's address and shift unchanged.
- R4: A slot entry whose top bit is set (-1 is written as all ones) is padding. That slot's `slot_valid` bit is 0 on the issued row, the row still issues, and a row that is padding in every slot still takes one cycle.
- R5: `cn_start` is high on the first row of a run, on row 0 of each iteration, and on each row that follows a check-node end. `cn_end` is high on rows whose `vec_cn_end` was set. The last program row always closes a check node, even when its marker is clear.
- R6: A row that reads, in some slot, an address that an earlier check node also read in that slot issues no earlier than WB_LAT+1 cycles after the edge at which that earlier check node's last row issued. `stall` is high in every cycle in which the row is held back. Reading the same address again within one check node causes no stall.
- R7: `iter_count` increments when the last row issues. When it reaches `iter_limit`, that row is the final one: `done` pulses for one cycle together with it, and `busy` falls.
- R8: `parity_ok` is sampled only at the issue of the last program row. If it is high then, the run ends after that iteration with a `done` pulse, whatever the limit.
- R9: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| iter_limit | input | IT_W | Maximum number of iterations (nonzero) |
| vec_rows | input | ROW_W | Number of program rows (nonzero) |
| parity_ok | input | 1 | Parity satisfied, sampled at the last row |
| vec_idx | output | ROW_W | Program row being considered |
| vec_addr | input | NSLOT*(ADDR_W+1) | Per-slot signed word address of row `vec_idx` |
| vec_shift | input | NSLOT*SH_W | Per-slot shift amount of row `vec_idx` |
| vec_cn_end | input | 1 | Row `vec_idx` closes a check node |
| busy | output | 1 | Run in progress |
| stall | output | 1 | Current row held back this cycle |
| row_issue | output | 1 | A row issued at the last edge |
| cn_start | output | 1 | Issued row opens a check node |
| cn_end | output | 1 | Issued row closes a check node |
| slot_valid | output | NSLOT | Slot accesses memory on the issued row |
| slot_addr | output | NSLOT*ADDR_W | Per-slot read word address |
| slot_shift | output | NSLOT*SH_W | Per-slot shift amount |
| iter_count | output | IT_W | Completed iterations in this run |
| done | output | 1 | One-cycle pulse at the final row |

## Verification
The assertions rely on a few properties of the inputs. The program entries must follow `vec_idx` in the same cycle. `iter_limit` and `vec_rows` must be nonzero and held steady for a whole run. The scoreboard depth must cover a check node's rows plus the write-back window. The bench meets these conditions by looking up its program table directly from `vec_idx`. It loads limits and row counts before raising `start` and keeps them unchanged until `busy` falls. Its programs use short check nodes, so no slot ever holds more than nine addresses in flight.

// File: rtl/ldpc_sched_pkg.sv
`timescale 1ns/1ps
package ldpc_sched_pkg;
    localparam int SLOTS_DEF    = 3;
    localparam int ADDR_W_DEF   = 4;
    localparam int SH_W_DEF     = 5;
    localparam int ROW_W_DEF    = 5;
    localparam int IT_W_DEF     = 4;
    localparam int WB_LAT_DEF   = 4;
    localparam int SB_DEPTH_DEF = 12;

    typedef enum logic {ST_IDLE, ST_RUN} sched_state_e;

    typedef struct packed {
        logic head;
        logic tail;
    } cn_flags_t;
endpackage

// File: rtl/ldpc_sched_sb.sv
`timescale 1ns/1ps
module ldpc_sched_sb #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              push,
    input  logic              close,
    output logic              hazard,
    output logic              full
);
    localparam int LAT_W = $clog2(LAT + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  opn;
    logic [ADDR_W-1:0] adr [DEPTH];
    logic [LAT_W-1:0]  tmr [DEPTH];

    logic             hit;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        hit      = 1'b0;
        any_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && !opn[i] && adr[i] == rd_addr) hit = 1'b1;
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign hazard = rd_en & hit;
    assign full   = ~any_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            opn <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                adr[i] <= '0;
                tmr[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && any_free && free_idx == IDX_W'(i)) begin
                    vld[i] <= 1'b1;
                    opn[i] <= ~close;
                    adr[i] <= rd_addr;
                    tmr[i] <= LAT_W'(LAT);
                end else if (vld[i] && opn[i]) begin
                    if (close) begin
                        opn[i] <= 1'b0;
                        tmr[i] <= LAT_W'(LAT);
                    end
                end else if (vld[i]) begin
                    if (tmr[i] == LAT_W'(1)) vld[i] <= 1'b0;
                    else                     tmr[i] <= tmr[i] - LAT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ldpc_sched_iter.sv
`timescale 1ns/1ps
module ldpc_sched_iter #(
    parameter int IT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  logic            wrap,
    input  logic            parity_ok,
    input  logic [IT_W-1:0] iter_limit,
    output logic            stop,
    output logic [IT_W-1:0] iter_count,
    output logic            done
);
    logic [IT_W:0] next_cnt;

    assign next_cnt = {1'b0, iter_count} + (IT_W+1)'(1);
    assign stop     = wrap & (parity_ok | (next_cnt >= {1'b0, iter_limit}));

    always_ff @(posedge clk) begin
        if (rst) begin
            iter_count <= '0;
            done       <= 1'b0;
        end else begin
            done <= stop;
            if (launch)    iter_count <= '0;
            else if (wrap) iter_count <= next_cnt[IT_W-1:0];
        end
    end
endmodule

// File: rtl/ldpc_slot_sched.sv
`timescale 1ns/1ps
module ldpc_slot_sched
    import ldpc_sched_pkg::*;
#(
    parameter int NSLOT    = SLOTS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int SH_W     = SH_W_DEF,
    parameter int ROW_W    = ROW_W_DEF,
    parameter int IT_W     = IT_W_DEF,
    parameter int WB_LAT   = WB_LAT_DEF,
    parameter int SB_DEPTH = SB_DEPTH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [IT_W-1:0]              iter_limit,
    input  logic [ROW_W-1:0]             vec_rows,
    input  logic                         parity_ok,
    output logic [ROW_W-1:0]             vec_idx,
    input  logic [NSLOT*(ADDR_W+1)-1:0]  vec_addr,
    input  logic [NSLOT*SH_W-1:0]        vec_shift,
    input  logic                         vec_cn_end,
    output logic                         busy,
    output logic                         stall,
    output logic                         row_issue,
    output logic                         cn_start,
    output logic                         cn_end,
    output logic [NSLOT-1:0]             slot_valid,
    output logic [NSLOT*ADDR_W-1:0]      slot_addr,
    output logic [NSLOT*SH_W-1:0]        slot_shift,
    output logic [IT_W-1:0]              iter_count,
    output logic                         done
);
    localparam int VA_W = ADDR_W + 1;

    sched_state_e      state;
    logic [ROW_W-1:0]  row_q;
    logic              head_q;
    logic [ROW_W-1:0]  last_idx;
    logic              last_row;
    logic              end_eff;
    logic              running;
    logic              issue;
    logic              blocked;
    logic              stop;
    logic              launch;
    cn_flags_t         flags;

    logic [NSLOT-1:0]  rd_en;
    logic [NSLOT-1:0]  haz;
    logic [NSLOT-1:0]  full;
    logic [ADDR_W-1:0] rd_addr [NSLOT];

    assign running  = (state == ST_RUN);
    assign last_idx = vec_rows - ROW_W'(1);
    assign last_row = (row_q == last_idx);
    assign end_eff  = vec_cn_end | last_row;
    assign blocked  = (|haz) | (|(full & rd_en));
    assign stall    = running & blocked;
    assign issue    = running & ~blocked;
    assign launch   = start & ~running;
    assign flags    = '{head: head_q, tail: end_eff};
    assign vec_idx  = row_q;
    assign busy     = running;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign rd_en[s]   = ~vec_addr[s*VA_W + ADDR_W];
        assign rd_addr[s] = vec_addr[s*VA_W +: ADDR_W];

        ldpc_sched_sb #(
            .ADDR_W (ADDR_W),
            .DEPTH  (SB_DEPTH),
            .LAT    (WB_LAT)
        ) u_sb (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (rd_en[s]),
            .rd_addr (rd_addr[s]),
            .push    (issue & rd_en[s]),
            .close   (issue & end_eff),
            .hazard  (haz[s]),
            .full    (full[s])
        );
    end

    ldpc_sched_iter #(.IT_W(IT_W)) u_iter (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .wrap       (issue & last_row),
        .parity_ok  (parity_ok),
        .iter_limit (iter_limit),
        .stop       (stop),
        .iter_count (iter_count),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            row_q      <= '0;
            head_q     <= 1'b0;
            row_issue  <= 1'b0;
            cn_start   <= 1'b0;
            cn_end     <= 1'b0;
            slot_valid <= '0;
            slot_addr  <= '0;
            slot_shift <= '0;
        end else begin
            row_issue  <= issue;
            cn_start   <= issue & flags.head;
            cn_end     <= issue & flags.tail;
            slot_valid <= issue ? rd_en : '0;
            if (issue) begin
                for (int s = 0; s < NSLOT; s++) begin
                    slot_addr[s*ADDR_W +: ADDR_W] <= rd_addr[s];
                end
                slot_shift <= vec_shift;
            end
            if (launch) begin
                state  <= ST_RUN;
                row_q  <= '0;
                head_q <= 1'b1;
            end else if (issue) begin
                head_q <= end_eff;
                row_q  <= last_row ? '0 : row_q + ROW_W'(1);
                if (stop) state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/ldpc_sched_checker.sv
`timescale 1ns/1ps
module ldpc_sched_checker #(
    parameter int NSLOT = 3,
    parameter int ROW_W = 5,
    parameter int IT_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             stall,
    input logic             row_issue,
    input logic [NSLOT-1:0] slot_valid,
    input logic             done,
    input logic [ROW_W-1:0] vec_idx,
    input logic [IT_W-1:0]  iter_count,
    input logic [IT_W-1:0]  iter_limit
);
    assert_stall_holds_row_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(vec_idx));

    assert_stall_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> busy);

    assert_slot_needs_row_R4: assert property (@(posedge clk) disable iff (rst)
        (|slot_valid) |-> row_issue);

    assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_count_below_limit_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (iter_count < iter_limit));
endmodule

bind ldpc_slot_sched ldpc_sched_checker #(
    .NSLOT (NSLOT),
    .ROW_W (ROW_W),
    .IT_W  (IT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .stall      (stall),
    .row_issue  (row_issue),
    .slot_valid (slot_valid),
    .done       (done),
    .vec_idx    (vec_idx),
    .iter_count (iter_count),
    .iter_limit (iter_limit)
);

// File: tb/tb_ldpc_slot_sched.sv
`timescale 1ns/1ps
module tb_ldpc_slot_sched;
    localparam int NSLOT = 3, ADDR_W = 4, SH_W = 5, ROW_W = 5, IT_W = 4;
    localparam int WB_LAT = 4, SB_DEPTH = 12, VA_W = ADDR_W + 1;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, parity_ok = 1'b0;
    logic [IT_W-1:0] iter_limit = '0;
    logic [ROW_W-1:0] vec_rows = '0;
    logic [ROW_W-1:0] vec_idx;
    logic [NSLOT*VA_W-1:0] vec_addr;
    logic [NSLOT*SH_W-1:0] vec_shift;
    logic vec_cn_end;
    logic busy, stall, row_issue, cn_start, cn_end, done;
    logic [NSLOT-1:0] slot_valid;
    logic [NSLOT*ADDR_W-1:0] slot_addr;
    logic [NSLOT*SH_W-1:0] slot_shift;
    logic [IT_W-1:0] iter_count;

    int prog_addr [16][3];
    int prog_shift [16][3];
    bit prog_end [16];
    int prog_rows = 1;
    int cyc = 0;
    int errors = 0, checks = 0;
    bit fin = 0;

    ldpc_slot_sched #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .SH_W(SH_W), .ROW_W(ROW_W),
        .IT_W(IT_W), .WB_LAT(WB_LAT), .SB_DEPTH(SB_DEPTH)) dut (
        .clk(clk), .rst(rst), .start(start), .iter_limit(iter_limit), .vec_rows(vec_rows),
        .parity_ok(parity_ok), .vec_idx(vec_idx), .vec_addr(vec_addr), .vec_shift(vec_shift),
        .vec_cn_end(vec_cn_end), .busy(busy), .stall(stall), .row_issue(row_issue),
        .cn_start(cn_start), .cn_end(cn_end), .slot_valid(slot_valid), .slot_addr(slot_addr),
        .slot_shift(slot_shift), .iter_count(iter_count), .done(done));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        vec_addr   = '0;
        vec_shift  = '0;
        vec_cn_end = 1'b0;
        if (int'(vec_idx) < 16) begin
            for (int s = 0; s < NSLOT; s++) begin
                vec_addr[s*VA_W +: VA_W] = (prog_addr[vec_idx][s] < 0) ? {VA_W{1'b1}}
                                           : VA_W'(prog_addr[vec_idx][s]);
                vec_shift[s*SH_W +: SH_W] = SH_W'(prog_shift[vec_idx][s]);
            end
            vec_cn_end = prog_end[vec_idx];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!fin) begin
            fin = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic bit end_of(input int r);
        return prog_end[r] || (r == prog_rows - 1);
    endfunction

    task automatic load_prog(input int p);
        for (int r = 0; r < 16; r++) begin
            prog_end[r] = 0;
            for (int s = 0; s < 3; s++) begin
                prog_addr[r][s] = -1;
                prog_shift[r][s] = 0;
            end
        end
        if (p == 0) begin
            prog_rows = 6;
            for (int r = 0; r < 6; r++) begin
                prog_addr[r][0] = r;
                prog_addr[r][1] = 8 + r / 2;
                prog_addr[r][2] = (r % 2 == 1) ? -1 : r;
                for (int s = 0; s < 3; s++) prog_shift[r][s] = (r * 7 + s * 11) % 30;
                prog_end[r] = (r % 2 == 1);
            end
        end else if (p == 1) begin
            prog_rows = 4;
            for (int r = 0; r < 4; r++) begin
                prog_addr[r][0] = 3;
                prog_addr[r][1] = r + 8;
                prog_addr[r][2] = -1;
                for (int s = 0; s < 3; s++) prog_shift[r][s] = r + s;
                prog_end[r] = 1;
            end
        end else begin
            prog_rows = 7;
            for (int r = 0; r < 7; r++) begin
                for (int s = 0; s < 3; s++) begin
                    prog_addr[r][s] = (r == 3) ? -1 : (r * 5 + s * 3) % 4;
                    prog_shift[r][s] = (r * 13 + s * 5) % 30;
                end
                prog_end[r] = (r == 2 || r == 4);
            end
        end
    endtask

    task automatic run_case(input int p, input int limit, input bit par, input bit poke);
        int exp_edge [64];
        int exp_row [64];
        int lc [3][16];
        bit op [3][16];
        int iters, total, t, st, k, r;
        load_prog(p);
        iter_limit = IT_W'(limit);
        vec_rows = ROW_W'(prog_rows);
        parity_ok = par;
        iters = par ? 1 : limit;
        total = iters * prog_rows;
        for (int s = 0; s < 3; s++)
            for (int a = 0; a < 16; a++) begin
                lc[s][a] = -1000;
                op[s][a] = 0;
            end
        @(negedge clk);
        start = 1'b1;
        st = cyc + 1;
        t = st;
        for (int i = 0; i < total; i++) begin
            int cand;
            r = i % prog_rows;
            cand = t + 1;
            for (int s = 0; s < 3; s++)
                if (prog_addr[r][s] >= 0 && lc[s][prog_addr[r][s]] + WB_LAT + 1 > cand)
                    cand = lc[s][prog_addr[r][s]] + WB_LAT + 1;
            for (int s = 0; s < 3; s++)
                if (prog_addr[r][s] >= 0) op[s][prog_addr[r][s]] = 1;
            if (end_of(r))
                for (int s = 0; s < 3; s++)
                    for (int a = 0; a < 16; a++)
                        if (op[s][a]) begin
                            lc[s][a] = cand;
                            op[s][a] = 0;
                        end
            exp_edge[i] = cand;
            exp_row[i] = r;
            t = cand;
        end
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (cyc <= exp_edge[total-1] + 3) begin
            if (k < total && cyc == exp_edge[k]) begin
                r = exp_row[k];
                chk(row_issue == 1'b1, "R2", "row issued", row_issue, 1);
                for (int s = 0; s < 3; s++) begin
                    chk(slot_valid[s] == (prog_addr[r][s] >= 0), "R4", "slot valid",
                        slot_valid[s], prog_addr[r][s] >= 0);
                    if (prog_addr[r][s] >= 0) begin
                        chk(int'(slot_addr[s*ADDR_W +: ADDR_W]) == prog_addr[r][s], "R3",
                            "slot addr", slot_addr[s*ADDR_W +: ADDR_W], prog_addr[r][s]);
                        chk(int'(slot_shift[s*SH_W +: SH_W]) == prog_shift[r][s], "R3",
                            "slot shift", slot_shift[s*SH_W +: SH_W], prog_shift[r][s]);
                    end
                end
                chk(cn_start == (r == 0 || end_of(r - 1)), "R5", "cn_start", cn_start,
                    r == 0 || end_of(r - 1));
                chk(cn_end == end_of(r), "R5", "cn_end", cn_end, end_of(r));
                chk(done == (k == total - 1), par ? "R8" : "R7", "done", done, k == total - 1);
                k++;
            end else begin
                chk(row_issue == 1'b0 && done == 1'b0, "R2", "idle cycle issue/done",
                    {row_issue, done}, 0);
            end
            chk(busy == (k < total), "R7", "busy", busy, k < total);
            if (k < total) begin
                chk(int'(vec_idx) == exp_row[k], "R2", "vec_idx", vec_idx, exp_row[k]);
                chk(stall == (exp_edge[k] != cyc + 1), "R6", "stall", stall,
                    exp_edge[k] != cyc + 1);
            end else begin
                chk(stall == 1'b0, "R6", "stall idle", stall, 0);
            end
            start = (poke && cyc == st + 3);
            @(negedge clk);
        end
        start = 1'b0;
        chk(int'(iter_count) == iters, poke ? "R9" : (par ? "R8" : "R7"), "iterations",
            iter_count, iters);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        load_prog(0);
        repeat (3) @(negedge clk);
        chk(busy == 0 && stall == 0 && row_issue == 0 && done == 0, "R1", "reset ctrl",
            {busy, stall, row_issue, done}, 0);
        chk(slot_valid == 0 && cn_start == 0 && cn_end == 0 && iter_count == 0, "R1",
            "reset outputs", {slot_valid, cn_start, cn_end, iter_count}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && row_issue == 0 && iter_count == 0, "R1", "after reset",
            {busy, row_issue, iter_count}, 0);
        run_case(0, 2, 1'b0, 1'b0);
        run_case(1, 3, 1'b0, 1'b1);
        run_case(2, 2, 1'b0, 1'b0);
        run_case(2, 4, 1'b1, 1'b0);
        run_case(0, 1, 1'b0, 1'b0);
        summary();
    end
endmodule